// File: doc/BRIEF.md
# Queued Memory-to-Memory DMA Command Engine

This block is a register-programmed DMA engine. Software loads a source address, a destination address, a source length and a destination length into four registers. Writing the destination length places a command built from all four values into a small in-order queue. The engine pops commands one at a time and moves data over a 32-bit word-wide memory master port. Each pass over the source, a burst, moves at most 1 KiB.

Two modes exist. In loopback mode each burst is read into a local buffer and then written back out to the destination. In the normal mode each source word is handed to a configuration sink that always accepts it, and the destination count is consumed on that path. Completion is reported through a write-1-to-clear interrupt status register and a mask register, which together drive one interrupt line. A read-only status word shows whether the queue is full or empty.

Top module: `qdma_engine`

## Requirements
- R1: A register write to offset 0x24 pushes one command made of the stored source address (0x18), the stored destination address (0x1C), the stored source length (0x20) and the value being written. When the command is captured, address bits [1:0] are cleared. Lengths are counts of 32-bit words.
- R2: The length registers at 0x20 and 0x24 keep only bits [26:0]. Their upper bits read as zero.
- R3: In loopback mode (misc register 0x80, bit 4) with both lengths nonzero, a burst is min(256 words, source remaining, destination remaining). All reads of a burst come from ascending source words before any of its writes, which go to ascending destination words with the same data.
- R4: In loopback mode a source remainder with a zero destination count is read but not written. A destination remainder with a zero source count is cleared with no memory access.
- R5: In normal mode each source word read appears on `cfgValid`/`cfgData`, and decrements a nonzero destination count. Any destination remainder is drained at one word per cycle. No memory write is issued.
- R6: When both counts of a command reach zero, interrupt status bits 13 and 12 are set and the command leaves the queue. Commands run in the order they were pushed.
- R7: The queue holds 4 commands, including the one running. Status bit 31 means full and bit 30 means empty. A push while full is dropped and sets interrupt status bit 14.
- R8: The interrupt status register (0x0C) resets to 0x8802_0000, and writing 1 to a bit clears it.
- R9: The interrupt mask (0x10) resets to all ones. `irq` is high when any status bit is set whose mask bit is zero.
- R10: The status register (0x14) is read-only and resets to 0x4000_0820.
- R11: In the misc register only bit 4 is writable. All other bits read as zero.
- R12: Once `memReq` is raised, it and `memAddr`/`memWrite` hold steady until a cycle with `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| irq | output | 1 | Interrupt line |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access accepted; read data valid in this cycle |
| memRdata | input | 32 | Read data |
| cfgValid | output | 1 | Source word presented to the sink (normal mode) |
| cfgData | output | 32 | Sink data |

## Verification
The hardest state to reach is a full command queue, because the engine normally drains commands as fast as they arrive. The bench holds back every memory acknowledge so that the first command stalls on its first read. It then pushes five commands, so it can see the full flag and the dropped fifth push, and check that the retained four run in push order once acknowledges resume. The memory model also withholds acknowledges in a repeating pattern during the main runs. This keeps held requests and the burst boundary at 256 words (a 300-word copy) under test.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  parameter int ADDR_W = 32;
  parameter int REG_W  = 32;
  parameter int LEN_W  = 27;
  parameter int RA_W   = 8;
  localparam int WADDR_W = ADDR_W - 2;

  localparam logic [RA_W-1:0] OFF_INT_STS  = 8'h0C;
  localparam logic [RA_W-1:0] OFF_INT_MASK = 8'h10;
  localparam logic [RA_W-1:0] OFF_STATUS   = 8'h14;
  localparam logic [RA_W-1:0] OFF_SRC_ADDR = 8'h18;
  localparam logic [RA_W-1:0] OFF_DST_ADDR = 8'h1C;
  localparam logic [RA_W-1:0] OFF_SRC_LEN  = 8'h20;
  localparam logic [RA_W-1:0] OFF_DST_LEN  = 8'h24;
  localparam logic [RA_W-1:0] OFF_MISC     = 8'h80;

  localparam int BIT_PDONE = 12;
  localparam int BIT_DONE  = 13;
  localparam int BIT_QOVF  = 14;
  localparam int BIT_LOOP  = 4;
  localparam int BIT_FULL  = 31;
  localparam int BIT_EMPTY = 30;

  localparam logic [REG_W-1:0] INT_STS_RESET = 32'h8802_0000;
  localparam logic [REG_W-1:0] INT_STS_IMPL  = 32'h8802_7000;
  localparam logic [REG_W-1:0] STATUS_CONST  = 32'h0000_0820;

  typedef struct packed {
    logic [WADDR_W-1:0] srcWord;
    logic [WADDR_W-1:0] dstWord;
    logic [LEN_W-1:0]   srcLen;
    logic [LEN_W-1:0]   dstLen;
  } dma_cmd_t;

  typedef struct packed {
    logic load;
    logic burstStart;
    logic rdStep;
    logic wrStart;
    logic wrStep;
    logic drainStep;
    logic finish;
  } ctrl_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_READ, ST_WRITE, ST_DRAIN
  } eng_state_t;
endpackage

// File: rtl/qdma_regs.sv
module qdma_regs
  import qdma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             finish,
  input  logic             qFull,
  input  logic             qEmpty,
  output logic             pushReq,
  output dma_cmd_t         pushCmd,
  output logic             loopback,
  output logic [REG_W-1:0] intMaskOut,
  output logic             irq
);
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [LEN_W-1:0]  srcLen, dstLen;
  logic [REG_W-1:0]  intSts, stsNext, intMask;
  logic              loopReg;

  assign pushReq = regWrEn && (regAddr == OFF_DST_LEN);

  always_comb begin
    stsNext = intSts;
    if (regWrEn && regAddr == OFF_INT_STS) stsNext = stsNext & ~regWdata;
    if (finish) begin
      stsNext[BIT_DONE]  = 1'b1;
      stsNext[BIT_PDONE] = 1'b1;
    end
    if (pushReq && qFull) stsNext[BIT_QOVF] = 1'b1;
    stsNext = stsNext & INT_STS_IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      srcLen  <= '0;
      dstLen  <= '0;
      intSts  <= INT_STS_RESET;
      intMask <= '1;
      loopReg <= 1'b0;
    end else begin
      intSts <= stsNext;
      if (regWrEn) begin
        case (regAddr)
          OFF_SRC_ADDR: srcAddr <= regWdata;
          OFF_DST_ADDR: dstAddr <= regWdata;
          OFF_SRC_LEN:  srcLen  <= regWdata[LEN_W-1:0];
          OFF_DST_LEN:  dstLen  <= regWdata[LEN_W-1:0];
          OFF_INT_MASK: intMask <= regWdata;
          OFF_MISC:     loopReg <= regWdata[BIT_LOOP];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    pushCmd.srcWord = srcAddr[ADDR_W-1:2];
    pushCmd.dstWord = dstAddr[ADDR_W-1:2];
    pushCmd.srcLen  = srcLen;
    pushCmd.dstLen  = regWdata[LEN_W-1:0];
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFF_INT_STS:  regRdata = intSts;
      OFF_INT_MASK: regRdata = intMask;
      OFF_STATUS: begin
        regRdata = STATUS_CONST;
        regRdata[BIT_FULL]  = qFull;
        regRdata[BIT_EMPTY] = qEmpty;
      end
      OFF_SRC_ADDR: regRdata = srcAddr;
      OFF_DST_ADDR: regRdata = dstAddr;
      OFF_SRC_LEN:  regRdata = {{(REG_W-LEN_W){1'b0}}, srcLen};
      OFF_DST_LEN:  regRdata = {{(REG_W-LEN_W){1'b0}}, dstLen};
      OFF_MISC:     regRdata[BIT_LOOP] = loopReg;
      default: ;
    endcase
  end

  assign loopback   = loopReg;
  assign intMaskOut = intMask;
  assign irq        = |(intSts & ~intMask);
endmodule

// File: rtl/qdma_cmdq.sv
module qdma_cmdq
  import qdma_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  dma_cmd_t      din,
  output dma_cmd_t      dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  dma_cmd_t      slots [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = slots[rdPtr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= din;
  end
endmodule

// File: rtl/qdma_ctrl.sv
module qdma_ctrl
  import qdma_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         qEmpty,
  input  logic         memAck,
  input  logic         srcZero,
  input  logic         dstZero,
  input  logic         lastIdx,
  input  logic         burstWr,
  output ctrl_strobe_t stb,
  output logic         memReq,
  output logic         memWrite
);
  eng_state_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb      = '0;
    nxt      = state;
    memReq   = 1'b0;
    memWrite = 1'b0;
    case (state)
      ST_IDLE: if (!qEmpty) begin
        stb.load = 1'b1;
        nxt      = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (srcZero && dstZero) begin
          stb.finish = 1'b1;
          nxt        = ST_IDLE;
        end else if (!srcZero) begin
          stb.burstStart = 1'b1;
          nxt            = ST_READ;
        end else begin
          nxt = ST_DRAIN;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.rdStep = 1'b1;
          if (lastIdx) begin
            if (burstWr) begin
              stb.wrStart = 1'b1;
              nxt         = ST_WRITE;
            end else begin
              nxt = ST_DECIDE;
            end
          end
        end
      end
      ST_WRITE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) begin
          stb.wrStep = 1'b1;
          if (lastIdx) nxt = ST_DECIDE;
        end
      end
      ST_DRAIN: begin
        if (dstZero) nxt = ST_DECIDE;
        else         stb.drainStep = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/qdma_datapath.sv
module qdma_datapath
  import qdma_pkg::*;
#(
  parameter int BURST_WORDS = 256,
  localparam int IW  = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1,
  localparam int BLW = $clog2(BURST_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      stb,
  input  logic              loopbackIn,
  input  logic              selWrite,
  input  dma_cmd_t          headCmd,
  input  logic [REG_W-1:0]  memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [REG_W-1:0]  memWdata,
  output logic              srcZero,
  output logic              dstZero,
  output logic              lastIdx,
  output logic              burstWr,
  output logic              cfgValid,
  output logic [REG_W-1:0]  cfgData
);
  logic [WADDR_W-1:0] curSrc, curDst;
  logic [LEN_W-1:0]   srcLeft, dstLeft, lim;
  logic [BLW-1:0]     burstLen, idx;
  logic               burstLoop, burstWrR;
  logic [REG_W-1:0]   bufMem [BURST_WORDS];

  always_comb begin
    lim = LEN_W'(BURST_WORDS);
    if (srcLeft < lim) lim = srcLeft;
    if (loopbackIn && dstLeft != '0 && dstLeft < lim) lim = dstLeft;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc    <= '0;
      curDst    <= '0;
      srcLeft   <= '0;
      dstLeft   <= '0;
      burstLen  <= '0;
      idx       <= '0;
      burstLoop <= 1'b0;
      burstWrR  <= 1'b0;
    end else begin
      if (stb.load) begin
        curSrc  <= headCmd.srcWord;
        curDst  <= headCmd.dstWord;
        srcLeft <= headCmd.srcLen;
        dstLeft <= headCmd.dstLen;
      end
      if (stb.burstStart) begin
        burstLen  <= BLW'(lim);
        burstLoop <= loopbackIn;
        burstWrR  <= loopbackIn && (dstLeft != '0);
      end
      if (stb.burstStart || stb.wrStart)    idx <= '0;
      else if (stb.rdStep || stb.wrStep)    idx <= idx + 1'b1;
      if (stb.rdStep) begin
        curSrc  <= curSrc + 1'b1;
        srcLeft <= srcLeft - 1'b1;
        if (!burstLoop && dstLeft != '0) dstLeft <= dstLeft - 1'b1;
      end
      if (stb.wrStep) begin
        curDst  <= curDst + 1'b1;
        dstLeft <= dstLeft - 1'b1;
      end
      if (stb.drainStep) dstLeft <= dstLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.rdStep) bufMem[idx[IW-1:0]] <= memRdata;
  end

  assign memWdata = bufMem[idx[IW-1:0]];
  assign memAddr  = {selWrite ? curDst : curSrc, 2'b00};
  assign srcZero  = (srcLeft == '0);
  assign dstZero  = (dstLeft == '0);
  assign lastIdx  = (idx == burstLen - 1'b1);
  assign burstWr  = burstWrR;
  assign cfgValid = stb.rdStep && !burstLoop;
  assign cfgData  = memRdata;
endmodule

// File: rtl/qdma_engine.sv
module qdma_engine
  import qdma_pkg::*;
#(
  parameter int CMD_DEPTH   = 4,
  parameter int BURST_BYTES = 1024,
  localparam int BURST_WORDS = BURST_BYTES / 4,
  localparam int QCW = $clog2(CMD_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  output logic        memReq,
  output logic        memWrite,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic [31:0] memRdata,
  output logic        cfgValid,
  output logic [31:0] cfgData
);
  ctrl_strobe_t    stb;
  dma_cmd_t        pushCmd, headCmd;
  logic            pushReq, qFull, qEmpty, loopback;
  logic            srcZero, dstZero, lastIdx, burstWr;
  logic [QCW-1:0]  qCount;
  logic [31:0]     intMask;

  qdma_regs u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .finish(stb.finish),
    .qFull(qFull), .qEmpty(qEmpty), .pushReq(pushReq), .pushCmd(pushCmd),
    .loopback(loopback), .intMaskOut(intMask), .irq(irq)
  );

  qdma_cmdq #(.DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rstN(rstN), .push(pushReq), .pop(stb.finish),
    .din(pushCmd), .dout(headCmd), .full(qFull), .empty(qEmpty),
    .count(qCount)
  );

  qdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .qEmpty(qEmpty), .memAck(memAck),
    .srcZero(srcZero), .dstZero(dstZero), .lastIdx(lastIdx),
    .burstWr(burstWr), .stb(stb), .memReq(memReq), .memWrite(memWrite)
  );

  qdma_datapath #(.BURST_WORDS(BURST_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loopbackIn(loopback),
    .selWrite(memWrite), .headCmd(headCmd), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .srcZero(srcZero),
    .dstZero(dstZero), .lastIdx(lastIdx), .burstWr(burstWr),
    .cfgValid(cfgValid), .cfgData(cfgData)
  );
endmodule

// File: rtl/qdma_engine_checker.sv
module qdma_engine_checker #(
  parameter int DEPTH = 4,
  localparam int QCW = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           memReq,
  input logic           memAck,
  input logic           memWrite,
  input logic [31:0]    memAddr,
  input logic           cfgValid,
  input logic           irq,
  input logic [31:0]    intMask,
  input logic [QCW-1:0] qCount,
  input logic           pushReq,
  input logic           popReq,
  input logic           qFull
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWrite));

  a_r5_sink_on_read: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> memReq && memAck && !memWrite);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (&intMask) |-> !irq);

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= QCW'(DEPTH));

  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && qFull && !popReq |=> $stable(qCount));

  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    popReq |-> qCount != '0);
endmodule

bind qdma_engine qdma_engine_checker #(.DEPTH(CMD_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck),
  .memWrite(memWrite), .memAddr(memAddr), .cfgValid(cfgValid), .irq(irq),
  .intMask(intMask), .qCount(qCount), .pushReq(pushReq),
  .popReq(stb.finish), .qFull(qFull)
);

// File: tb/qdma_engine_bench.sv
module qdma_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq, memReq, memWrite, cfgValid;
  logic [31:0] memAddr, memWdata, cfgData;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  always #4 clk = ~clk;

  qdma_engine u_qdma_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .cfgValid(cfgValid),
    .cfgData(cfgData)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] mem [4096];
  bit          ackEnable = 1;
  int          cyc = 0;
  int          rdCnt, wrCnt, sinkCnt, firstWr;
  logic [31:0] sinkSum;
  logic [31:0] rdLog [16];

  function automatic logic [31:0] pattern(input int w);
    return (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic clearCounters();
    rdCnt = 0; wrCnt = 0; sinkCnt = 0; firstWr = -1; sinkSum = '0;
  endtask

  // memory model: decides acknowledge on the falling edge
  initial begin
    bit          prevStall = 0;
    logic [31:0] prevAddr = '0;
    logic        prevWr = 1'b0;
    clearCounters();
    for (int i = 0; i < 4096; i++) mem[i] = pattern(i);
    forever begin
      @(negedge clk);
      cyc++;
      if (prevStall) begin
        check(memReq && memAddr == prevAddr && memWrite == prevWr,
              "R12 request held", memAddr, prevAddr);
      end
      memAck = 1'b0;
      if (memReq && ackEnable && (cyc % 3 != 0)) begin
        memAck = 1'b1;
        if (memWrite) begin
          mem[memAddr[13:2]] = memWdata;
          if (firstWr < 0) firstWr = rdCnt;
          wrCnt++;
        end else begin
          memRdata = mem[memAddr[13:2]];
          if (rdCnt < 16) rdLog[rdCnt] = memAddr;
          rdCnt++;
        end
      end
      prevStall = rstN && memReq && !memAck;
      prevAddr  = memAddr;
      prevWr    = memWrite;
      #1;
      if (cfgValid) begin
        sinkCnt++;
        sinkSum = sinkSum + cfgData;
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pushCmd(input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] sw, input logic [31:0] dw);
    regWrite(8'h18, s);
    regWrite(8'h1C, d);
    regWrite(8'h20, sw);
    regWrite(8'h24, dw);
  endtask

  task automatic waitEmpty();
    logic [31:0] st;
    st = '0;
    while (!st[30]) regRead(8'h14, st);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic        lb;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] sw;
    logic [31:0] dw;
    logic [31:0] expRd;
    logic [31:0] expWr;
    logic [31:0] expSink;
    logic [31:0] expFirstWr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0100, 32'h2000, 32'd8,   32'd8,   32'd8,   32'd8,   32'd0,  32'd8},
    '{1'b1, 32'h0203, 32'h2102, 32'd5,   32'd3,   32'd5,   32'd3,   32'd0,  32'd3},
    '{1'b1, 32'h0400, 32'h2400, 32'd300, 32'd300, 32'd300, 32'd300, 32'd0,  32'd256},
    '{1'b0, 32'h1000, 32'h3000, 32'd10,  32'd4,   32'd10,  32'd0,   32'd10, 32'd0},
    '{1'b0, 32'h1100, 32'h3100, 32'd2,   32'd7,   32'd2,   32'd0,   32'd2,  32'd0},
    '{1'b1, 32'h1200, 32'h3200, 32'd0,   32'd6,   32'd0,   32'd0,   32'd0,  32'd0},
    '{1'b1, 32'h1300, 32'h3300, 32'd0,   32'd0,   32'd0,   32'd0,   32'd0,  32'd0},
    '{1'b1, 32'h1400, 32'h3400, 32'd3,   32'd9,   32'd3,   32'd3,   32'd0,  32'd3}
  };

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset values
    regRead(8'h0C, r); check(r == 32'h8802_0000, "R8 int status reset", r, 32'h8802_0000);
    regRead(8'h10, r); check(r == 32'hFFFF_FFFF, "R9 mask reset", r, 32'hFFFF_FFFF);
    regRead(8'h14, r); check(r == 32'h4000_0820, "R10 status reset", r, 32'h4000_0820);
    check(irq == 1'b0, "R9 irq low at reset", 32'(irq), 32'd0);

    // write-1-to-clear of a single bit
    regWrite(8'h0C, 32'h8000_0000);
    regRead(8'h0C, r); check(r == 32'h0802_0000, "R8 w1c single bit", r, 32'h0802_0000);
    regWrite(8'h14, 32'h0000_0000);
    regRead(8'h14, r); check(r == 32'h4000_0820, "R10 status read-only", r, 32'h4000_0820);

    // length masking (no push: 0x20 only)
    regWrite(8'h20, 32'hFFFF_FFFF);
    regRead(8'h20, r); check(r == 32'h07FF_FFFF, "R2 src length mask", r, 32'h07FF_FFFF);
    regWrite(8'h20, 32'h0);
    regWrite(8'h18, 32'h0);

    // misc register
    regWrite(8'h80, 32'hFFFF_FFFF);
    regRead(8'h80, r); check(r == 32'h0000_0010, "R11 misc only bit 4", r, 32'h10);

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      regWrite(8'h0C, 32'hFFFF_FFFF);
      regWrite(8'h80, {27'd0, t.lb, 4'd0});
      clearCounters();
      pushCmd(t.src, t.dst, t.sw, t.dw);
      waitEmpty();
      check(rdCnt == int'(t.expRd), t.lb ? "R3 read count" : "R5 read count",
            32'(rdCnt), t.expRd);
      check(wrCnt == int'(t.expWr), t.lb ? "R4 write count" : "R5 no writes",
            32'(wrCnt), t.expWr);
      check(sinkCnt == int'(t.expSink), "R5 sink words", 32'(sinkCnt), t.expSink);
      regRead(8'h0C, r);
      check(r[13:12] == 2'b11, "R6 done bits", r, 32'h3000);
      if (t.expRd != 0)
        check(rdLog[0] == {t.src[31:2], 2'b00}, "R1 aligned source", rdLog[0],
              {t.src[31:2], 2'b00});
      if (t.expWr != 0) begin
        check(firstWr == int'(t.expFirstWr), "R3 burst precedes writes",
              32'(firstWr), t.expFirstWr);
        for (int i = 0; i < int'(t.expWr); i++) begin
          int dw, sw;
          dw = int'(t.dst[13:2]) + i;
          sw = int'(t.src[13:2]) + i;
          if (mem[dw] != pattern(sw) || i == 0)
            check(mem[dw] == pattern(sw), "R3 copied data", mem[dw], pattern(sw));
        end
        if (!t.lb) ;
      end
      if (!t.lb && t.expSink != 0) begin
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < int'(t.sw); i++) s = s + pattern(int'(t.src[13:2]) + i);
        check(sinkSum == s, "R5 sink data", sinkSum, s);
      end
    end

    // overflow of the command queue with memory held off
    regWrite(8'h0C, 32'hFFFF_FFFF);
    regWrite(8'h80, 32'h10);
    clearCounters();
    ackEnable = 0;
    for (int k = 0; k < 4; k++) pushCmd(32'h1800 + 32'(16 * k), 32'h3800 + 32'(16 * k), 1, 1);
    regRead(8'h14, r); check(r[31:30] == 2'b10, "R7 full flag", r, 32'h8000_0820);
    regRead(8'h0C, r); check(r[14] == 1'b0, "R7 no overflow yet", r, 32'h0);
    pushCmd(32'h1900, 32'h3900, 1, 1);
    regRead(8'h0C, r); check(r[14] == 1'b1, "R7 overflow bit", r, 32'h4000);
    ackEnable = 1;
    waitEmpty();
    check(rdCnt == 4, "R7 dropped push", 32'(rdCnt), 32'd4);
    for (int k = 0; k < 4; k++)
      check(rdLog[k] == 32'h1800 + 32'(16 * k), "R6 push order", rdLog[k],
            32'h1800 + 32'(16 * k));

    // interrupt line
    regWrite(8'h0C, 32'hFFFF_FFFF);
    check(irq == 1'b0, "R9 irq after clear", 32'(irq), 32'd0);
    regWrite(8'h10, ~32'h2000);
    pushCmd(32'h1A00, 32'h3A00, 2, 2);
    waitEmpty();
    check(irq == 1'b1, "R9 irq unmasked done", 32'(irq), 32'd1);
    regWrite(8'h0C, 32'h2000);
    check(irq == 1'b0, "R9 irq masked partial", 32'(irq), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule